// File: doc/BRIEF.md
# Machine State Register Update Unit

This block owns the 64-bit machine state register of a 64-bit core that has no hypervisor mode. Five events reach the register: a synchronous reset, interrupt entry, return from interrupt, a move-to-register operation with a one-bit scope flag, and a move-from-register read. Each event touches its own subset of bits. Some bits are forced, some are copied from a 64-bit source operand, and the rest keep their value. The block also drives a decrementer interrupt request, which is qualified by the external-interrupt enable bit.

Each cycle the operation decoder turns the one-hot strobe, the interrupt-take pulse and the scope flag into one named operation: `OPK_IDLE`, `OPK_IRQ`, `OPK_RFI`, `OPK_MT_FULL`, `OPK_MT_PART` or `OPK_READ`. The register process then loads either the reset value or the next value for that operation. Any operation may move to any other on the next cycle. `OPK_IRQ` wins over every strobe. An all-zero or multi-bit strobe gives `OPK_IDLE`. `OPK_READ` and `OPK_IDLE` leave the register as it is.

Bit positions are numbered LSB-0: SF=63, EE=15, PR=14, IR=5, DR=4, RI=1, LE=0. Bit 60 is the hypervisor bit and bit 12 is the machine-check enable.

Top module: `msr_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `msr_q` becomes 64'h8000_0000_0000_0001 (SF and LE set, every other bit clear).
- R2: When `irq_take` is high, the next `msr_q` has SF and LE set, has EE, PR, IR, DR and RI clear, and keeps all other bits.
- R3: When `irq_take` is high together with any strobe, the interrupt-entry update of R2 is applied and the strobed operation is not.
- R4: `op_strobe` = 3'b001 (return) loads source bits 63:31, 26:22 and 15:0 into the register, and keeps bits 30:27 and 21:16.
- R5: On return, when source bit 14 is 1, bits 15, 5 and 4 become 1 whatever the source holds there.
- R6: `op_strobe` = 3'b010 (move-to) with `l_field` = 1 loads only bits 15 and 1 from the source. All other bits are kept.
- R7: Move-to with `l_field` = 0 loads source bits 63:61, 59:13 and 11:1, and keeps bits 60, 12 and 0.
- R8: Move-to with `l_field` = 0 and source bit 14 equal to 1 forces bits 15, 5 and 4 to 1.
- R9: In a cycle with `op_strobe` = 3'b100 (read), `rd_valid` is 1 and `rd_data` equals all 64 bits of `msr_q`. In any other strobe cycle `rd_valid` is 0. A read does not change the register.
- R10: `dec_irq_req` is 1 exactly when `msr_q[15]` is 1 and `dec_msb` is 1.
- R11: With no interrupt, an all-zero strobe or a strobe with more than one bit set leaves `msr_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_strobe | input | 3 | One-hot operation: bit0 return, bit1 move-to, bit2 read |
| l_field | input | 1 | Move-to scope flag: 1 updates EE and RI only |
| irq_take | input | 1 | Interrupt-entry pulse, highest priority |
| src_data | input | 64 | Source operand for return and move-to |
| dec_msb | input | 1 | Sign bit of the decrementer counter |
| msr_q | output | 64 | Current register value |
| rd_data | output | 64 | Read result |
| rd_valid | output | 1 | Read result valid this cycle |
| dec_irq_req | output | 1 | Decrementer interrupt request |

## Verification
Every operation is driven with a walking one and a walking zero over all 64 source bits. A walking one shows for each single bit whether it is copied, forced or kept. A walking zero shows whether a bit is kept or wrongly cleared. Pseudo-random words, with the PR bit both set and clear, bring out the forcing rules and the bits a move-to must skip. Collisions between the interrupt pulse and each strobe, illegal multi-bit strobes and all four enable/sign combinations cover priority, idle holding and the request qualification.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int XLEN = 64;

    localparam int B_SF = 63;
    localparam int B_HV = 60;
    localparam int B_EE = 15;
    localparam int B_PR = 14;
    localparam int B_ME = 12;
    localparam int B_IR = 5;
    localparam int B_DR = 4;
    localparam int B_RI = 1;
    localparam int B_LE = 0;

    localparam int STB_W    = 3;
    localparam int STB_RFI  = 0;
    localparam int STB_MT   = 1;
    localparam int STB_READ = 2;

    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    localparam logic [XLEN-1:0] RESET_VAL = (ONE << B_SF) | (ONE << B_LE);

    // bits copied on return; partial-function bits 30:27 and 21:16 are kept
    localparam logic [XLEN-1:0] RFI_MASK =
        {33'h1_FFFF_FFFF, 4'h0, 5'h1F, 6'h00, 16'hFFFF};

    // bits copied by a full move-to; HV, ME and LE are kept
    localparam logic [XLEN-1:0] MT_FULL_MASK =
        ~((ONE << B_HV) | (ONE << B_ME) | (ONE << B_LE));

    localparam logic [XLEN-1:0] MT_PART_MASK = (ONE << B_EE) | (ONE << B_RI);

    // forced on when problem state ends up set
    localparam logic [XLEN-1:0] PR_FORCE = (ONE << B_EE) | (ONE << B_IR) | (ONE << B_DR);

    localparam logic [XLEN-1:0] IRQ_SET = (ONE << B_SF) | (ONE << B_LE);
    localparam logic [XLEN-1:0] IRQ_CLR = (ONE << B_EE) | (ONE << B_PR) |
                                          (ONE << B_IR) | (ONE << B_DR) | (ONE << B_RI);

    typedef enum logic [2:0] {
        OPK_IDLE,
        OPK_IRQ,
        OPK_RFI,
        OPK_MT_FULL,
        OPK_MT_PART,
        OPK_READ
    } op_kind_t;

endpackage

// File: rtl/msr_op_decode.sv
module msr_op_decode
    import msr_pkg::*;
(
    input  logic [STB_W-1:0] op_strobe,
    input  logic             l_field,
    input  logic             irq_take,
    output op_kind_t         op_kind
);

    localparam logic [STB_W-1:0] S_RFI  = STB_W'(1) << STB_RFI;
    localparam logic [STB_W-1:0] S_MT   = STB_W'(1) << STB_MT;
    localparam logic [STB_W-1:0] S_READ = STB_W'(1) << STB_READ;

    always_comb begin
        op_kind = OPK_IDLE;
        if (irq_take) begin
            op_kind = OPK_IRQ;
        end else begin
            unique case (op_strobe)
                S_RFI:   op_kind = OPK_RFI;
                S_MT:    op_kind = l_field ? OPK_MT_PART : OPK_MT_FULL;
                S_READ:  op_kind = OPK_READ;
                default: op_kind = OPK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/msr_next_calc.sv
module msr_next_calc
    import msr_pkg::*;
(
    input  op_kind_t        op_kind,
    input  logic [XLEN-1:0] cur,
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] nxt
);

    logic [XLEN-1:0] rfi_val;
    logic [XLEN-1:0] mt_full_val;
    logic [XLEN-1:0] mt_part_val;
    logic [XLEN-1:0] irq_val;
    logic            src_pr;

    assign src_pr = src[B_PR];

    always_comb begin
        rfi_val     = (src & RFI_MASK) | (cur & ~RFI_MASK);
        mt_full_val = (src & MT_FULL_MASK) | (cur & ~MT_FULL_MASK);
        mt_part_val = (src & MT_PART_MASK) | (cur & ~MT_PART_MASK);
        irq_val     = (cur & ~IRQ_CLR) | IRQ_SET;
        if (src_pr) begin
            rfi_val     = rfi_val | PR_FORCE;
            mt_full_val = mt_full_val | PR_FORCE;
        end
    end

    always_comb begin
        unique case (op_kind)
            OPK_IRQ:     nxt = irq_val;
            OPK_RFI:     nxt = rfi_val;
            OPK_MT_FULL: nxt = mt_full_val;
            OPK_MT_PART: nxt = mt_part_val;
            default:     nxt = cur;
        endcase
    end

endmodule

// File: rtl/msr_unit.sv
module msr_unit
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STB_W-1:0] op_strobe,
    input  logic             l_field,
    input  logic             irq_take,
    input  logic [XLEN-1:0]  src_data,
    input  logic             dec_msb,
    output logic [XLEN-1:0]  msr_q,
    output logic [XLEN-1:0]  rd_data,
    output logic             rd_valid,
    output logic             dec_irq_req
);

    op_kind_t        op_kind;
    logic [XLEN-1:0] msr_nxt;

    msr_op_decode u_dec (
        .op_strobe (op_strobe),
        .l_field   (l_field),
        .irq_take  (irq_take),
        .op_kind   (op_kind)
    );

    msr_next_calc u_calc (
        .op_kind (op_kind),
        .cur     (msr_q),
        .src     (src_data),
        .nxt     (msr_nxt)
    );

    // register process
    always_ff @(posedge clk) begin
        if (rst) begin
            msr_q <= RESET_VAL;
        end else begin
            msr_q <= msr_nxt;
        end
    end

    // output process
    always_comb begin
        rd_valid    = (op_strobe == (STB_W'(1) << STB_READ));
        rd_data     = msr_q;
        dec_irq_req = msr_q[B_EE] & dec_msb;
    end

endmodule

// File: rtl/msr_unit_chk.sv
module msr_unit_chk
    import msr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [STB_W-1:0] op_strobe,
    input logic             l_field,
    input logic             irq_take,
    input logic [XLEN-1:0]  src_data,
    input logic [XLEN-1:0]  msr_q
);

    logic is_rfi, is_mt_full, is_mt_part, is_idle;

    assign is_rfi     = !irq_take && op_strobe == 3'b001;
    assign is_mt_full = !irq_take && op_strobe == 3'b010 && !l_field;
    assign is_mt_part = !irq_take && op_strobe == 3'b010 && l_field;
    assign is_idle    = !irq_take && !$onehot(op_strobe);

    assert_irq_entry_R2: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> (msr_q[B_SF] && msr_q[B_LE] && !msr_q[B_EE] && !msr_q[B_PR] &&
                      !msr_q[B_IR] && !msr_q[B_DR] && !msr_q[B_RI]));

    assert_rfi_keep_partial_R4: assert property (@(posedge clk) disable iff (rst)
        is_rfi |=> ($stable(msr_q[30:27]) && $stable(msr_q[21:16])));

    assert_pr_force_R5_R8: assert property (@(posedge clk) disable iff (rst)
        ((is_rfi || is_mt_full) && src_data[B_PR]) |=>
            (msr_q[B_EE] && msr_q[B_IR] && msr_q[B_DR]));

    assert_mt_part_scope_R6: assert property (@(posedge clk) disable iff (rst)
        is_mt_part |=> (((msr_q ^ $past(msr_q)) & ~MT_PART_MASK) == '0));

    assert_mt_full_keep_R7: assert property (@(posedge clk) disable iff (rst)
        is_mt_full |=> ($stable(msr_q[B_HV]) && $stable(msr_q[B_ME]) && $stable(msr_q[B_LE])));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        is_idle |=> $stable(msr_q));

endmodule

bind msr_unit msr_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_strobe (op_strobe),
    .l_field   (l_field),
    .irq_take  (irq_take),
    .src_data  (src_data),
    .msr_q     (msr_q)
);

// File: tb/msr_unit_bench.sv
`timescale 1ns/1ps
module msr_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_strobe = '0;
    logic        l_field = 1'b0;
    logic        irq_take = 1'b0;
    logic [63:0] src_data = '0;
    logic        dec_msb = 1'b0;
    logic [63:0] msr_q, rd_data;
    logic        rd_valid, dec_irq_req;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [63:0] mdl;

    always #2 clk = ~clk;

    msr_unit u_msr_unit (
        .clk(clk), .rst(rst), .op_strobe(op_strobe), .l_field(l_field),
        .irq_take(irq_take), .src_data(src_data), .dec_msb(dec_msb),
        .msr_q(msr_q), .rd_data(rd_data), .rd_valid(rd_valid), .dec_irq_req(dec_irq_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [63:0] cur, input logic [2:0] s,
                                          input logic l, input logic irq, input logic [63:0] d);
        logic [63:0] r;
        r = cur;
        if (irq) begin
            r[63] = 1'b1; r[0] = 1'b1;
            r[15] = 1'b0; r[14] = 1'b0; r[5] = 1'b0; r[4] = 1'b0; r[1] = 1'b0;
        end else if (s == 3'b001) begin
            for (int i = 0; i < 64; i++)
                if (!((i >= 27 && i <= 30) || (i >= 16 && i <= 21))) r[i] = d[i];
            if (d[14]) begin r[15] = 1'b1; r[5] = 1'b1; r[4] = 1'b1; end
        end else if (s == 3'b010 && l) begin
            r[15] = d[15]; r[1] = d[1];
        end else if (s == 3'b010) begin
            for (int i = 0; i < 64; i++)
                if (i != 60 && i != 12 && i != 0) r[i] = d[i];
            if (d[14]) begin r[15] = 1'b1; r[5] = 1'b1; r[4] = 1'b1; end
        end
        return r;
    endfunction

    task automatic step(input string req, input logic [2:0] s, input logic l,
                        input logic irq, input logic [63:0] d);
        @(negedge clk);
        op_strobe = s; l_field = l; irq_take = irq; src_data = d;
        #0.5;
        check({req, "/rd_valid"}, {63'd0, rd_valid}, {63'd0, (s == 3'b100)});
        if (s == 3'b100) check({req, "/R9 rd_data"}, rd_data, mdl);
        mdl = model(mdl, s, l, irq, d);
        @(posedge clk);
        #1;
        check(req, msr_q, mdl);
        op_strobe = '0; irq_take = 1'b0;
    endtask

    initial begin
        logic [63:0] lf;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value", msr_q, 64'h8000_0000_0000_0001);
        mdl = 64'h8000_0000_0000_0001;
        @(negedge clk);
        rst = 1'b0;

        // walking one / walking zero sweeps over every source bit
        for (int b = 0; b < 64; b++) begin
            step("R4 rfi walk1", 3'b001, 1'b0, 1'b0, 64'd1 << b);
            step("R7 mt full walk0", 3'b010, 1'b0, 1'b0, ~(64'd1 << b));
            step("R6 mt part walk1", 3'b010, 1'b1, 1'b0, 64'd1 << b);
            step("R4 rfi walk0", 3'b001, 1'b0, 1'b0, ~(64'd1 << b));
            step("R7 mt full walk1", 3'b010, 1'b0, 1'b0, 64'd1 << b);
            step("R6 mt part walk0", 3'b010, 1'b1, 1'b0, ~(64'd1 << b));
            step("R9 read", 3'b100, 1'b0, 1'b0, ~(64'd1 << b));
        end

        // pseudo-random words, PR set and clear
        lf = 64'hACE1_2468_1357_9BDF;
        for (int k = 0; k < 48; k++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            step("R5 rfi rand", 3'b001, 1'b0, 1'b0, lf ^ (64'(k[0]) << 14));
            step("R9 read", 3'b100, 1'b0, 1'b0, lf);
            step("R8 mt full rand", 3'b010, 1'b0, 1'b0, ~lf ^ (64'(k[1]) << 14));
            step("R6 mt part rand", 3'b010, 1'b1, 1'b0, lf);
            step("R11 idle", 3'b000, 1'b0, 1'b0, lf);
            step("R11 multi strobe", 3'b011, 1'b0, 1'b0, ~lf);
            step("R11 multi strobe", 3'b111, k[0], 1'b0, lf);
            step("R2 irq entry", 3'b000, 1'b0, 1'b1, lf);
            step("R3 irq beats rfi", 3'b001, 1'b0, 1'b1, ~lf);
            step("R3 irq beats mt", 3'b010, k[0], 1'b1, ~lf);
            step("R3 irq beats read", 3'b100, 1'b0, 1'b1, lf);
        end

        // decrementer request, all combinations
        for (int e = 0; e < 2; e++) begin
            step("R6 set EE", 3'b010, 1'b1, 1'b0, 64'(e) << 15);
            for (int m = 0; m < 2; m++) begin
                @(negedge clk);
                dec_msb = m[0];
                #1;
                check("R10 dec request", {63'd0, dec_irq_req}, {63'd0, e[0] & m[0]});
            end
            dec_msb = 1'b0;
        end

        // reset from a modified value
        step("R8 mt full", 3'b010, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset again", msr_q, 64'h8000_0000_0000_0001);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule